// File: doc/BRIEF.md
# Programmable Clock Divider with Selectable Divisor Encoding

This block divides an incoming clock by a ratio that software holds in a 32-bit control register. A write port updates the register, and a read port returns it. The ratio sits in a bit field at a configurable offset and width. The block decodes that field into an effective divisor under one of four encodings: field-plus-one, raw one-based, power of two, or a lookup list. Two pins select optional behaviour. One lets a zero one-based field mean a plain bypass. The other turns on half-word masked writes, in which the upper 16 bits of a write enable the lower 16 bits bit by bit.

A decoded divisor is first held as pending. The counter adopts it only when the current output period ends, so a ratio change never produces a shortened pulse. A setting that cannot be decoded leaves the previous divisor in place and raises a sticky error flag. A later write that decodes cleanly clears the flag. A divisor of one routes the input clock straight to the output.

Top module: `clkdiv_top`

## Requirements
- R1: The divider field is bits [SHIFT+WIDTH-1:SHIFT] of the control register (bits [7:4] by default), and the other bits do not affect the divisor. With half-word masking off, a write stores all 32 bits, and rd_data_o returns the register.
- R2: With enc_mode_i = 0 (plus-one), a write sets the divisor to the field value plus one.
- R3: With enc_mode_i = 1 (one-based), the divisor equals the field value. A zero field is invalid when allow_zero_i is 0.
- R4: With enc_mode_i = 1 and allow_zero_i = 1, a zero field gives divisor 1. While the divisor is 1, clk_o follows clk_i.
- R5: With enc_mode_i = 2 (power of two), the divisor is 2 raised to the field value.
- R6: With enc_mode_i = 3 (lookup), the field is matched against this ordered list of value:divisor pairs: 1:3, 2:5, 4:6, 7:0, 6:9, 8:4. The scan stops at the first entry whose divisor is 0. A value with no match before that entry is invalid, so 6, 7 and 8 are invalid.
- R7: With hiword_i = 1, a write changes register bit k (k < 16) only if write bit 16+k is 1. Register bits [31:16] become 0.
- R8: A new divisor reaches div_o and the counter only in the clock cycle after the current output period ends. div_o stays unchanged in every other cycle.
- R9: An invalid write leaves the pending divisor unchanged and sets err_o. err_o stays set until a write that decodes validly clears it.
- R10: For a divisor D of 2 or more, clk_o is high for ceil(D/2) input cycles and low for floor(D/2) input cycles in each period.
- R11: After reset, the control register is 0, div_o is 1 (bypass) and err_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enc_mode_i | input | 2 | Divisor encoding: 0 plus-one, 1 one-based, 2 power of two, 3 lookup |
| allow_zero_i | input | 1 | One-based mode: a zero field means bypass |
| hiword_i | input | 1 | Enables writes masked by the upper half-word |
| wr_en_i | input | 1 | Write strobe for the control register |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Current control register contents |
| clk_o | output | 1 | Divided output clock |
| div_o | output | DIVW | Divisor currently in effect |
| err_o | output | 1 | Sticky flag for an invalid setting |

## Verification
A register write and the end of an output period can land on the same input edge. The divisor already pending must then be adopted, and the freshly written one must wait a full further period. The bench writes new ratios at arbitrary phases of a running divider, so over the run this coincidence occurs for several divisors. A behavioural model updated on every edge judges each cycle: it applies the period-end adoption before the write and then compares div_o, err_o, the register and the clock level. Invalid writes made while a change is still pending show whether the error path leaves the pending value alone.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  typedef enum logic [1:0] {
    ENC_PLUS1 = 2'd0,
    ENC_ONEB  = 2'd1,
    ENC_POW2  = 2'd2,
    ENC_TABLE = 2'd3
  } enc_e;

  localparam int LUT_N  = 6;
  localparam int LUT_VW = 8;
  localparam int LUT_DW = 16;

  // Ordered value/divisor pairs; a zero divisor closes the list.
  localparam logic [LUT_VW-1:0] LUT_VAL [LUT_N] = '{8'd1, 8'd2, 8'd4, 8'd7, 8'd6, 8'd8};
  localparam logic [LUT_DW-1:0] LUT_DIV [LUT_N] = '{16'd3, 16'd5, 16'd6, 16'd0, 16'd9, 16'd4};

endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs #(
  parameter int SHIFT = 4,
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [31:0]      wr_data_i,
  input  logic             hiword_i,
  output logic [31:0]      ctrl_o,
  output logic [WIDTH-1:0] field_nxt_o
);
  localparam int HALF = 16;

  logic [31:0]     ctrl_q;
  logic [31:0]     ctrl_d;
  logic [HALF-1:0] bit_en;
  logic [HALF-1:0] low_merge;

  assign bit_en    = wr_data_i[31:HALF];
  assign low_merge = (ctrl_q[HALF-1:0] & ~bit_en) | (wr_data_i[HALF-1:0] & bit_en);

  always_comb begin
    if (hiword_i) ctrl_d = {{HALF{1'b0}}, low_merge};
    else          ctrl_d = wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (wr_en_i) ctrl_q <= ctrl_d;
  end

  assign ctrl_o      = ctrl_q;
  assign field_nxt_o = ctrl_d[SHIFT +: WIDTH];
endmodule

// File: rtl/clkdiv_decode.sv
module clkdiv_decode
  import clkdiv_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter int DIVW  = 16
) (
  input  logic [WIDTH-1:0] field_i,
  input  logic [1:0]       mode_i,
  input  logic             allow_zero_i,
  output logic [DIVW-1:0]  div_o,
  output logic             valid_o
);
  logic [LUT_N-1:0] live;
  logic [LUT_N-1:0] hit;
  logic [DIVW-1:0]  lut_div;
  logic             lut_hit;
  enc_e             mode;

  assign mode = enc_e'(mode_i);

  always_comb begin
    logic run;
    run = 1'b1;
    for (int i = 0; i < LUT_N; i++) begin
      run     = run && (LUT_DIV[i] != '0);
      live[i] = run;
    end
  end

  for (genvar g = 0; g < LUT_N; g++) begin : g_lut
    assign hit[g] = live[g] && (32'(LUT_VAL[g]) == 32'(field_i));
  end

  always_comb begin
    lut_div = '0;
    lut_hit = 1'b0;
    for (int i = LUT_N - 1; i >= 0; i--) begin
      if (hit[i]) begin
        lut_hit = 1'b1;
        lut_div = DIVW'(LUT_DIV[i]);
      end
    end
  end

  always_comb begin
    div_o   = DIVW'(1);
    valid_o = 1'b1;
    unique case (mode)
      ENC_PLUS1: div_o = DIVW'(field_i) + DIVW'(1);
      ENC_ONEB: begin
        if (field_i == '0) begin
          div_o   = DIVW'(1);
          valid_o = allow_zero_i;
        end else begin
          div_o = DIVW'(field_i);
        end
      end
      ENC_POW2: div_o = DIVW'(1) << field_i;
      ENC_TABLE: begin
        div_o   = lut_div;
        valid_o = lut_hit;
      end
      default: valid_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/clkdiv_gen.sv
module clkdiv_gen #(
  parameter int DIVW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [DIVW-1:0] pend_i,
  output logic            clk_o,
  output logic [DIVW-1:0] div_o,
  output logic [DIVW-1:0] cnt_o,
  output logic            wrap_o
);
  logic [DIVW-1:0] cnt_q, cnt_d;
  logic [DIVW-1:0] act_q, act_d;
  logic            out_q, out_d;
  logic [DIVW:0]   half_d;
  logic            wrap;
  logic            bypass;

  assign wrap = (cnt_q == act_q - DIVW'(1));

  always_comb begin
    if (wrap) begin
      cnt_d = '0;
      act_d = pend_i;
    end else begin
      cnt_d = cnt_q + DIVW'(1);
      act_d = act_q;
    end
    half_d = ({1'b0, act_d} + (DIVW+1)'(1)) >> 1;
    out_d  = ({1'b0, cnt_d} < half_d);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= DIVW'(1);
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
      out_q <= out_d;
    end
  end

  assign bypass = (act_q == DIVW'(1));
  assign clk_o  = bypass ? clk_i : out_q;
  assign div_o  = act_q;
  assign cnt_o  = cnt_q;
  assign wrap_o = wrap;
endmodule

// File: rtl/clkdiv_top.sv
module clkdiv_top #(
  parameter int SHIFT = 4,
  parameter int WIDTH = 4,
  parameter int DIVW  = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      enc_mode_i,
  input  logic            allow_zero_i,
  input  logic            hiword_i,
  input  logic            wr_en_i,
  input  logic [31:0]     wr_data_i,
  output logic [31:0]     rd_data_o,
  output logic            clk_o,
  output logic [DIVW-1:0] div_o,
  output logic            err_o
);
  logic [WIDTH-1:0] field_nxt;
  logic [DIVW-1:0]  dec_div;
  logic             dec_valid;
  logic [DIVW-1:0]  pend_q;
  logic             err_q;
  logic [DIVW-1:0]  cnt;
  logic             wrap;

  clkdiv_regs #(.SHIFT(SHIFT), .WIDTH(WIDTH)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .hiword_i    (hiword_i),
    .ctrl_o      (rd_data_o),
    .field_nxt_o (field_nxt)
  );

  clkdiv_decode #(.WIDTH(WIDTH), .DIVW(DIVW)) u_dec (
    .field_i      (field_nxt),
    .mode_i       (enc_mode_i),
    .allow_zero_i (allow_zero_i),
    .div_o        (dec_div),
    .valid_o      (dec_valid)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= DIVW'(1);
      err_q  <= 1'b0;
    end else if (wr_en_i) begin
      if (dec_valid) pend_q <= dec_div;
      err_q <= ~dec_valid;
    end
  end

  clkdiv_gen #(.DIVW(DIVW)) u_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pend_i (pend_q),
    .clk_o  (clk_o),
    .div_o  (div_o),
    .cnt_o  (cnt),
    .wrap_o (wrap)
  );

  assign err_o = err_q;
endmodule

// File: rtl/clkdiv_chk.sv
module clkdiv_chk #(
  parameter int DIVW = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            hiword_i,
  input logic            wr_en_i,
  input logic [31:0]     wr_data_i,
  input logic [31:0]     rd_data_o,
  input logic [DIVW-1:0] div_o,
  input logic            err_o,
  input logic            dec_valid,
  input logic [DIVW-1:0] pend_q,
  input logic [DIVW-1:0] cnt,
  input logic            wrap
);
  AST_DIV_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap |=> $stable(div_o)); // R8
  AST_DIV_ADOPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> (div_o == $past(pend_q))); // R8
  AST_BAD_KEEPS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !dec_valid) |=> $stable(pend_q)); // R9
  AST_BAD_SETS_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !dec_valid) |=> err_o); // R9
  AST_GOOD_CLEARS_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && dec_valid) |=> !err_o); // R9
  AST_DIV_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_o != '0); // R9
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt < div_o); // R10
  AST_HW_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && hiword_i) |=> (rd_data_o[31:16] == 16'h0)); // R7
  AST_HW_MASKED_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && hiword_i) |=>
      (((rd_data_o[15:0] ^ $past(rd_data_o[15:0])) & ~$past(wr_data_i[31:16])) == 16'h0)); // R7
endmodule

bind clkdiv_top clkdiv_chk #(.DIVW(DIVW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .hiword_i  (hiword_i),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .rd_data_o (rd_data_o),
  .div_o     (div_o),
  .err_o     (err_o),
  .dec_valid (dec_valid),
  .pend_q    (pend_q),
  .cnt       (cnt),
  .wrap      (wrap)
);

// File: tb/tb_clkdiv_top.sv
`timescale 1ns/1ps
module tb_clkdiv_top;
  localparam int DIVW = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [1:0]      mode = 2'd0;
  logic            az = 1'b0;
  logic            hw = 1'b0;
  logic            wr_en = 1'b0;
  logic [31:0]     wr_data = 32'h0;
  logic [31:0]     rd_data;
  logic            clk_o;
  logic [DIVW-1:0] div_o;
  logic            err_o;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  clkdiv_top #(.SHIFT(4), .WIDTH(4), .DIVW(DIVW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .enc_mode_i(mode), .allow_zero_i(az),
    .hiword_i(hw), .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_data),
    .clk_o(clk_o), .div_o(div_o), .err_o(err_o)
  );

  task automatic chk(input string tag, input logic [31:0] a, input logic [31:0] e);
    tests++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, a, e, $time);
    end
  endtask

  // Reference model: behavioural state, stepped on each rising edge.
  int    m_ctrl, m_pend, m_act, m_cnt;
  bit    m_err;
  int    lut_v[6] = '{1, 2, 4, 7, 6, 8};
  int    lut_d[6] = '{3, 5, 6, 0, 9, 4};

  function automatic void ref_decode(input int f, input int md, input bit zok,
                                     output bit ok, output int d);
    ok = 1'b1;
    d  = 1;
    if (md == 0) d = f + 1;
    else if (md == 1) begin
      if (f == 0) ok = zok;
      else d = f;
    end else if (md == 2) d = 1 << f;
    else begin
      ok = 1'b0;
      foreach (lut_v[i]) begin
        if (lut_d[i] == 0) break;
        if (!ok && lut_v[i] == f) begin
          ok = 1'b1;
          d  = lut_d[i];
        end
      end
    end
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; m_pend = 1; m_act = 1; m_cnt = 0; m_err = 1'b0;
    end else begin
      bit ok;
      int d;
      if (m_cnt == m_act - 1) begin
        m_cnt = 0;
        m_act = m_pend;
      end else begin
        m_cnt = m_cnt + 1;
      end
      if (wr_en) begin
        if (hw) m_ctrl = ((m_ctrl & ~int'(wr_data[31:16])) | (int'(wr_data[15:0]) & int'(wr_data[31:16]))) & 32'hFFFF;
        else    m_ctrl = int'(wr_data);
        ref_decode((m_ctrl >> 4) & 15, int'(mode), az, ok, d);
        if (ok) m_pend = d;
        m_err = !ok;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R8 div_o", 32'(div_o), 32'(m_act));
      chk("R9 err_o", 32'(err_o), 32'(m_err));
      chk("R1 rd_data", rd_data, 32'(m_ctrl));
      if (m_act == 1) chk("R4 clk_o low", 32'(clk_o), 32'd0);
      else            chk("R10 clk_o", 32'(clk_o), 32'(m_cnt < (m_act + 1) / 2));
    end
  end

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_high(input int n, output int h);
    h = 0;
    repeat (n) begin
      @(negedge clk);
      #1;
      h += int'(clk_o);
    end
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<100000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int h;
    idle(3);
    #1;
    chk("R11 ctrl after reset", rd_data, 32'h0);
    chk("R11 div after reset", 32'(div_o), 32'd1);
    chk("R11 err after reset", 32'(err_o), 32'd0);
    rst_n = 1'b1;
    idle(2);

    // R2 / R1: plus-one, junk outside the field
    mode = 2'd0;
    wr(32'hF00F_003F);
    idle(20);
    chk("R2 plus-one div", 32'(div_o), 32'd4);
    chk("R1 full write", rd_data, 32'hF00F_003F);
    count_high(20, h);
    chk("R10 even duty", 32'(h), 32'd10);

    wr(32'h0000_0040);
    idle(20);
    chk("R2 plus-one div 5", 32'(div_o), 32'd5);
    count_high(20, h);
    chk("R10 odd duty", 32'(h), 32'd12);

    // R8: writes at several phases of a running divider
    for (int k = 0; k < 7; k++) begin
      wr(32'((k % 4 + 1) << 4));
      idle(k);
    end
    idle(20);
    chk("R8 final div", 32'(div_o), 32'd4);

    // R3 / R9: one-based
    mode = 2'd1;
    wr(32'h0000_0060);
    idle(20);
    chk("R3 one-based div", 32'(div_o), 32'd6);
    wr(32'h0000_0000);
    idle(20);
    chk("R9 err set", 32'(err_o), 32'd1);
    chk("R9 div kept", 32'(div_o), 32'd6);
    wr(32'h0000_0020);
    idle(20);
    chk("R9 err cleared", 32'(err_o), 32'd0);
    chk("R3 one-based div 2", 32'(div_o), 32'd2);

    // R4: allow-zero bypass
    az = 1'b1;
    wr(32'h0000_0000);
    idle(20);
    chk("R4 bypass div", 32'(div_o), 32'd1);
    @(posedge clk); #1;
    chk("R4 clk_o follows high", 32'(clk_o), 32'd1);
    @(negedge clk); #1;
    chk("R4 clk_o follows low", 32'(clk_o), 32'd0);
    az = 1'b0;

    // R5: power of two
    mode = 2'd2;
    wr(32'h0000_0030);
    idle(20);
    chk("R5 pow2 div", 32'(div_o), 32'd8);

    // R6: lookup list
    mode = 2'd3;
    wr(32'h0000_0040);
    idle(20);
    chk("R6 lut 4", 32'(div_o), 32'd6);
    wr(32'h0000_0060);
    idle(3);
    chk("R6 after end invalid", 32'(err_o), 32'd1);
    wr(32'h0000_0070);
    idle(3);
    chk("R6 terminator invalid", 32'(err_o), 32'd1);
    idle(20);
    chk("R6 div kept", 32'(div_o), 32'd6);
    wr(32'h0000_0010);
    idle(20);
    chk("R6 lut 1", 32'(div_o), 32'd3);
    chk("R6 err clear", 32'(err_o), 32'd0);

    // R7: half-word masked writes
    mode = 2'd0;
    wr(32'hABCD_0030);
    idle(10);
    hw = 1'b1;
    wr(32'h000F_00A5);
    idle(20);
    chk("R7 masked bits", rd_data, 32'h0000_0035);
    chk("R7 field untouched", 32'(div_o), 32'd4);
    wr(32'h00F0_0077);
    idle(20);
    chk("R7 field written", rd_data, 32'h0000_0075);
    chk("R7 div", 32'(div_o), 32'd8);
    wr(32'h0000_FFFF);
    idle(3);
    chk("R7 no enables", rd_data, 32'h0000_0075);
    hw = 1'b0;
    idle(10);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule